// File: doc/BRIEF.md
# Read-Once Secret Word Store

This block keeps a device secret as a row of equal-width words in ordinary flip-flops. Each word sits behind a small read-only bus made of chip select, byte address and combinational read data. Trusted firmware may fetch the words in any order. Each word can be fetched once between resets, and only while the application-mode input is low. The first granted read of a word sets a sticky per-word flag. From the next clock edge on, that word reads as zero, even if chip select stays high. Only reset clears the flags.

Two name words and a version word sit at the bottom of the address space. They can be read any number of times, in either mode. The secret comes from an elaboration parameter that is reloaded at reset. A build option decides how a consumed word is hidden: it can be erased from its register, or masked at the output while the register stays constant.

Top module: `sec_word_vault`

## Requirements
- R1: After reset, a read of address BASE_ADDR+i (BASE_ADDR defaults to 0x10, i from 0 to NUM_WORDS-1) with application mode low returns word i, which is bits [i*WORD_W +: WORD_W] of SECRET_INIT.
- R2: `ready_o` equals `cs_i` in the same cycle, and `rdata_o` is zero whenever `cs_i` is low.
- R3: Address 0x00 returns NAME_LO, 0x01 returns NAME_HI and 0x02 returns VERSION. These reads are repeatable and are allowed in either mode.
- R4: A read of any address outside 0x00 to 0x02 and outside the secret window returns zero.
- R5: A clock edge that sees `cs_i` high, application mode low and a secret address consumes that word, and every later read of it returns zero until reset.
- R6: Consuming one word leaves every other word readable, whatever the read order.
- R7: While `app_mode_i` is high, secret reads return zero and consume nothing. The same word is still readable once the mode drops.
- R8: If `cs_i` stays high on one secret address across a clock edge, the word shows during the cycle before that edge and zero from the cycle after it.
- R9: Asserting `rst_n` low re-arms every word.
- R10: Only reset clears a consumed flag. Name, version and unmapped reads do not restore a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| app_mode_i | input | 1 | High while untrusted application code runs; blocks secret reads |
| cs_i | input | 1 | Chip select for a read |
| addr_i | input | ADDR_W | Word address |
| rdata_o | output | WORD_W | Combinational read data |
| ready_o | output | 1 | Read data valid; follows `cs_i` |

## Verification
The bench builds the block with its defaults: eight 32-bit words at 0x10, with the erase-on-read variant. SECRET_INIT is set to eight distinct non-zero patterns, so a word returned from the wrong slot, a word wrongly blanked and a word leaked after use are all told apart. Eight words in a 3-bit index reach both the lowest and the highest window address. The unmapped probes at 0x0F and 0x18 sit on each side of the window. Two reset cycles, two read orders and a held chip select exercise the re-arm and the timing of the flag.

// File: rtl/sec_vault_pkg.sv
package sec_vault_pkg;

   // identification registers sit at the first addresses of the map
   localparam int unsigned ID_COUNT = 3;

   typedef enum logic [1:0] {
      ID_NAME_LO = 2'd0,
      ID_NAME_HI = 2'd1,
      ID_VERSION = 2'd2
   } id_reg_e;

   typedef enum logic {
      HIDE_MASK  = 1'b0,
      HIDE_ERASE = 1'b1
   } hide_mode_e;

endpackage

// File: rtl/sec_vault_decode.sv
module sec_vault_decode
   import sec_vault_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_WORDS = 8,
   parameter int unsigned BASE_ADDR = 16
) (
   input  logic                 cs_i,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic                 app_mode_i,
   output logic [NUM_WORDS-1:0] grant_o,
   output logic [ID_COUNT-1:0]  id_sel_o
);

   localparam int unsigned IDX_W = $clog2(NUM_WORDS);
   localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(BASE_ADDR);

   logic in_window;

   // window is aligned, so the upper address bits alone identify it
   assign in_window = cs_i && !app_mode_i &&
                      (addr_i[ADDR_W-1:IDX_W] == WIN_BASE[ADDR_W-1:IDX_W]);

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_grant
      assign grant_o[i] = in_window && (addr_i[IDX_W-1:0] == IDX_W'(i));
   end

   for (genvar k = 0; k < ID_COUNT; k++) begin : g_id
      assign id_sel_o[k] = cs_i && (addr_i == ADDR_W'(k));
   end

endmodule

// File: rtl/sec_vault_slot.sv
module sec_vault_slot
   import sec_vault_pkg::*;
#(
   parameter int unsigned       WORD_W = 32,
   parameter logic [WORD_W-1:0] INIT   = '0,
   parameter hide_mode_e        HIDE   = HIDE_ERASE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              grant_i,
   output logic [WORD_W-1:0] word_o,
   output logic              spent_o
);

   logic              spent_q;
   logic [WORD_W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       spent_q <= 1'b0;
      else if (grant_i) spent_q <= 1'b1;
   end

   if (HIDE == HIDE_ERASE) begin : g_erase
      logic [WORD_W-1:0] data_q;
      // the value leaves the register on its first use
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       data_q <= INIT;
         else if (grant_i) data_q <= '0;
      end
      assign held = data_q;
   end else begin : g_mask
      assign held = INIT;
   end

   assign word_o  = (grant_i && !spent_q) ? held : '0;
   assign spent_o = spent_q;

endmodule

// File: rtl/sec_vault_ident.sv
module sec_vault_ident
   import sec_vault_pkg::*;
#(
   parameter int unsigned       WORD_W  = 32,
   parameter logic [WORD_W-1:0] NAME_LO = '0,
   parameter logic [WORD_W-1:0] NAME_HI = '0,
   parameter logic [WORD_W-1:0] VERSION = '0
) (
   input  logic [ID_COUNT-1:0] id_sel_i,
   output logic [WORD_W-1:0]   data_o
);

   assign data_o = ({WORD_W{id_sel_i[ID_NAME_LO]}} & NAME_LO) |
                   ({WORD_W{id_sel_i[ID_NAME_HI]}} & NAME_HI) |
                   ({WORD_W{id_sel_i[ID_VERSION]}} & VERSION);

endmodule

// File: rtl/sec_word_vault.sv
module sec_word_vault
   import sec_vault_pkg::*;
#(
   parameter int unsigned                 WORD_W      = 32,
   parameter int unsigned                 NUM_WORDS   = 8,
   parameter int unsigned                 ADDR_W      = 8,
   parameter int unsigned                 BASE_ADDR   = 16,
   parameter logic [NUM_WORDS*WORD_W-1:0] SECRET_INIT = '0,
   parameter logic [WORD_W-1:0]           NAME_LO     = 'h5345_4356,
   parameter logic [WORD_W-1:0]           NAME_HI     = 'h4155_4C54,
   parameter logic [WORD_W-1:0]           VERSION     = 'h0000_0102,
   parameter hide_mode_e                  HIDE        = HIDE_ERASE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              app_mode_i,
   input  logic              cs_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [WORD_W-1:0] rdata_o,
   output logic              ready_o
);

   // elaboration checks on the parameter set
   if (NUM_WORDS < 2 || (NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_count
      $error("NUM_WORDS must be a power of two of at least 2");
   end
   if (BASE_ADDR % NUM_WORDS != 0) begin : g_bad_align
      $error("BASE_ADDR must be aligned to NUM_WORDS");
   end
   if (BASE_ADDR < ID_COUNT) begin : g_bad_overlap
      $error("secret window overlaps identification registers");
   end
   if (ADDR_W > 31 || BASE_ADDR + NUM_WORDS > (1 << ADDR_W)) begin : g_bad_fit
      $error("secret window does not fit the address bus");
   end
   if (WORD_W < 8) begin : g_bad_width
      $error("WORD_W must be at least 8");
   end

   logic [NUM_WORDS-1:0] grant;
   logic [ID_COUNT-1:0]  id_sel;
   logic [NUM_WORDS-1:0] consumed_q;
   logic [WORD_W-1:0]    slot_word [NUM_WORDS];
   logic [WORD_W-1:0]    id_word;
   logic [WORD_W-1:0]    secret_word;

   sec_vault_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_WORDS (NUM_WORDS),
      .BASE_ADDR (BASE_ADDR)
   ) u_decode (
      .cs_i       (cs_i),
      .addr_i     (addr_i),
      .app_mode_i (app_mode_i),
      .grant_o    (grant),
      .id_sel_o   (id_sel)
   );

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_slot
      sec_vault_slot #(
         .WORD_W (WORD_W),
         .INIT   (SECRET_INIT[i*WORD_W +: WORD_W]),
         .HIDE   (HIDE)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .grant_i (grant[i]),
         .word_o  (slot_word[i]),
         .spent_o (consumed_q[i])
      );
   end

   sec_vault_ident #(
      .WORD_W  (WORD_W),
      .NAME_LO (NAME_LO),
      .NAME_HI (NAME_HI),
      .VERSION (VERSION)
   ) u_ident (
      .id_sel_i (id_sel),
      .data_o   (id_word)
   );

   // at most one slot drives a non-zero word, so an OR tree merges them
   always_comb begin
      secret_word = '0;
      for (int i = 0; i < NUM_WORDS; i++) begin
         secret_word = secret_word | slot_word[i];
      end
   end

   assign rdata_o = secret_word | id_word;
   assign ready_o = cs_i;

endmodule

// File: rtl/sec_vault_chk.sv
module sec_vault_chk #(
   parameter int unsigned                 WORD_W      = 32,
   parameter int unsigned                 NUM_WORDS   = 8,
   parameter int unsigned                 ADDR_W      = 8,
   parameter int unsigned                 BASE_ADDR   = 16,
   parameter logic [NUM_WORDS*WORD_W-1:0] SECRET_INIT = '0,
   parameter logic [WORD_W-1:0]           NAME_LO     = '0
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 app_mode_i,
   input logic                 cs_i,
   input logic [ADDR_W-1:0]    addr_i,
   input logic [WORD_W-1:0]    rdata_o,
   input logic [NUM_WORDS-1:0] spent_i
);

   localparam int unsigned IDX_W = $clog2(NUM_WORDS);

   logic                 hit;
   logic                 is_id;
   logic [IDX_W-1:0]     idx;
   logic [NUM_WORDS-1:0] shadow_q;

   assign hit   = (int'(addr_i) >= int'(BASE_ADDR)) &&
                  (int'(addr_i) < int'(BASE_ADDR + NUM_WORDS));
   assign is_id = int'(addr_i) < 3;
   assign idx   = IDX_W'(int'(addr_i) - int'(BASE_ADDR));

   // independent record of which words the bus has consumed
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shadow_q <= '0;
      else if (cs_i && hit && !app_mode_i) shadow_q[idx] <= 1'b1;
   end

   p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && hit && !app_mode_i && !shadow_q[idx]) |->
         rdata_o == SECRET_INIT[idx*WORD_W +: WORD_W]);

   p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_i |-> rdata_o == '0);

   p_ident_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && addr_i == '0) |-> rdata_o == NAME_LO);

   p_unmapped_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && !hit && !is_id) |-> rdata_o == '0);

   p_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && hit && shadow_q[idx]) |-> rdata_o == '0);

   p_app_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && hit && app_mode_i) |-> rdata_o == '0);

   p_app_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_i && app_mode_i) |=> $stable(spent_i));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((spent_i & $past(spent_i)) == $past(spent_i)));

endmodule

bind sec_word_vault sec_vault_chk #(
   .WORD_W      (WORD_W),
   .NUM_WORDS   (NUM_WORDS),
   .ADDR_W      (ADDR_W),
   .BASE_ADDR   (BASE_ADDR),
   .SECRET_INIT (SECRET_INIT),
   .NAME_LO     (NAME_LO)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .app_mode_i (app_mode_i),
   .cs_i       (cs_i),
   .addr_i     (addr_i),
   .rdata_o    (rdata_o),
   .spent_i    (consumed_q)
);

// File: tb/sec_word_vault_tb.sv
module sec_word_vault_tb;

   localparam int unsigned W = 32;
   localparam int unsigned N = 8;
   localparam logic [7:0]  BASE = 8'h10;
   localparam logic [31:0] NAME_LO = 32'h5345_4356;
   localparam logic [31:0] NAME_HI = 32'h4155_4C54;
   localparam logic [31:0] VERSION = 32'h0000_0102;

   function automatic logic [31:0] pat(int i);
      return {8'h5C ^ 8'(i), 8'h3A + 8'(i), ~8'(i), 8'(i * 17)};
   endfunction

   function automatic logic [N*W-1:0] build_secret();
      logic [N*W-1:0] s;
      for (int i = 0; i < N; i++) s[i*W +: W] = pat(i);
      return s;
   endfunction

   localparam logic [N*W-1:0] SECRET = build_secret();

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        app_mode = 1'b0;
   logic        cs = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] rdata;
   logic        ready;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   sec_word_vault #(
      .WORD_W      (W),
      .NUM_WORDS   (N),
      .ADDR_W      (8),
      .BASE_ADDR   (16),
      .SECRET_INIT (SECRET),
      .NAME_LO     (NAME_LO),
      .NAME_HI     (NAME_HI),
      .VERSION     (VERSION)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .app_mode_i (app_mode),
      .cs_i       (cs),
      .addr_i     (addr),
      .rdata_o    (rdata),
      .ready_o    (ready)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; cs = 1'b0; app_mode = 1'b0; addr = '0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // one access: cs high for one clock edge, sampled mid-cycle
   task automatic access(logic [7:0] a, logic app, output logic [31:0] d);
      @(negedge clk);
      cs = 1'b1; addr = a; app_mode = app;
      #1;
      d = rdata;
      check("R2 ready", 32'(ready), 32'd1);
      @(negedge clk);
      cs = 1'b0; app_mode = 1'b0;
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      do_reset();
      #1;
      check("R2 idle rdata", rdata, '0);
      check("R2 idle ready", 32'(ready), 32'd0);
      access(BASE + 8'd2, 1'b0, d);
      #1;
      check("R2 rdata after cs drop", rdata, '0);
   endtask

   task automatic t_ident();
      logic [31:0] d;
      do_reset();
      for (int r = 0; r < 2; r++) begin
         access(8'h00, 1'(r), d); check("R3 name lo", d, NAME_LO);
         access(8'h01, 1'(r), d); check("R3 name hi", d, NAME_HI);
         access(8'h02, 1'(r), d); check("R3 version", d, VERSION);
      end
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      logic [7:0] probes [5] = '{8'h03, 8'h0F, 8'h18, 8'h80, 8'hFF};
      do_reset();
      foreach (probes[k]) begin
         access(probes[k], 1'b0, d);
         check("R4 unmapped", d, '0);
      end
      access(BASE, 1'b0, d);
      check("R10 unmapped reads leave word 0 intact", d, pat(0));
   endtask

   task automatic t_app_block();
      logic [31:0] d;
      do_reset();
      access(BASE + 8'd3, 1'b1, d);
      check("R7 blocked in app mode", d, '0);
      access(BASE + 8'd3, 1'b1, d);
      check("R7 still blocked", d, '0);
      access(BASE + 8'd3, 1'b0, d);
      check("R7 not consumed by blocked read", d, pat(3));
      access(BASE + 8'd3, 1'b0, d);
      check("R5 second read zero", d, '0);
   endtask

   task automatic t_order_up();
      logic [31:0] d;
      do_reset();
      for (int i = 0; i < N; i++) begin
         access(BASE + 8'(i), 1'b0, d);
         check("R1 first read ascending", d, pat(i));
      end
      for (int i = 0; i < N; i++) begin
         access(BASE + 8'(i), 1'b0, d);
         check("R5 repeat read", d, '0);
      end
      access(8'h01, 1'b0, d);
      access(8'h2A, 1'b0, d);
      access(BASE + 8'd4, 1'b0, d);
      check("R10 no restore by other reads", d, '0);
   endtask

   task automatic t_hold_then_mixed();
      logic [31:0] d;
      int order [7] = '{6, 2, 7, 0, 4, 1, 3};
      do_reset();
      @(negedge clk);
      cs = 1'b1; addr = BASE + 8'd5;
      #1;
      check("R8 held cs before edge", rdata, pat(5));
      @(negedge clk);
      #1;
      check("R8 held cs after edge", rdata, '0);
      cs = 1'b0;
      foreach (order[k]) begin
         access(BASE + 8'(order[k]), 1'b0, d);
         check("R6 mixed order", d, pat(order[k]));
      end
      access(BASE + 8'd5, 1'b0, d);
      check("R5 held word stays blank", d, '0);
      do_reset();
      access(BASE + 8'd5, 1'b0, d);
      check("R9 re-armed by reset", d, pat(5));
      access(BASE + 8'd7, 1'b0, d);
      check("R9 other word re-armed", d, pat(7));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset_state();
      t_ident();
      t_unmapped();
      t_app_block();
      t_order_up();
      t_hold_then_mixed();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule